// File: doc/BRIEF.md
# Rename Undo Log with Youngest-First Rollback

This block keeps an ordered log of register renames so that the rename map and the free pool of physical registers can be put back into a precise state after a mispredicted path. Each renamed destination adds one entry at the young end of the log. An entry holds the instruction's sequence number, the architectural register, the physical register just given to it, and the physical register that mapping replaced. An instruction with no destination adds one marker entry that carries only its sequence number.

When an instruction retires, the oldest entry is removed and the physical register it replaced is returned to the free pool. When the pipeline is flushed back to a boundary sequence number, the log is walked from its youngest entry toward its oldest, one entry per cycle. For each entry younger than the boundary it tells the map to point the architectural register back at its previous physical register, and it returns the newly given physical register to the free pool. The map and the free pool live outside this block. They are driven through the restore and free command outputs. A full flag holds back the rename logic, and a busy flag covers the whole rollback walk.

Top module: `rename_undo_log`

## Requirements
- R1: After reset, `full`, `busy`, `restore_valid` and `free_valid` are all 0.
- R2: An entry is written when `push_valid` is 1, `full` is 0 and `busy` is 0. `full` is 1 exactly when DEPTH entries are held. A push offered while `full` is 1 is dropped and never later retired.
- R3: A `commit_valid` pulse whose `commit_seq` equals the sequence number of the oldest entry removes that entry. If the entry has a destination, the next cycle shows `free_valid`=1 with `free_preg` equal to its previous physical register. An instruction with k destinations retires with k pulses.
- R4: Retiring a marker entry (pushed with `push_has_dest`=0) removes it with no free pulse.
- R5: A commit on an empty log, or whose sequence number differs from the oldest entry's, is ignored. There is no free pulse and the oldest entry stays in place.
- R6: A `squash_valid` pulse accepted while not busy raises `busy` from the next cycle. Each later cycle removes the youngest entry while its sequence number is younger than `squash_seq`. The cycle after each removal of a destination entry shows `restore_valid`=1 with `restore_areg`/`restore_preg` set to its architectural and previous physical register, and `free_valid`=1 with `free_preg` set to its new physical register.
- R7: Removing a marker entry during a walk takes one cycle and produces neither a restore nor a free pulse.
- R8: The walk stops at the first entry not younger than the boundary, or when the log is empty. `busy` then falls and older entries remain retirable.
- R9: While `busy` is 1, pushes, commits and squashes are ignored. A squash and a commit in the same cycle: the squash is taken and the commit is dropped.
- R10: Entry sequence number A is younger than boundary B when (A - B), taken as a signed SEQ_W-bit value, is greater than zero. Ordering therefore survives wrap past all-ones.
- R11: `restore_valid` is never 1 without `free_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Add one entry at the young end |
| push_seq | input | SEQ_W | Sequence number of the renamed instruction |
| push_has_dest | input | 1 | 1: destination entry, 0: marker entry |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Physical register newly assigned |
| push_prev_preg | input | PREG_W | Physical register previously mapped |
| full | output | 1 | Log holds DEPTH entries |
| commit_valid | input | 1 | Retire request |
| commit_seq | input | SEQ_W | Sequence number being retired |
| squash_valid | input | 1 | Start a rollback |
| squash_seq | input | SEQ_W | Boundary; younger entries are undone |
| busy | output | 1 | Rollback walk in progress |
| restore_valid | output | 1 | Map restore command |
| restore_areg | output | AREG_W | Architectural register to restore |
| restore_preg | output | PREG_W | Physical register to map it back to |
| free_valid | output | 1 | Free-pool return command |
| free_preg | output | PREG_W | Physical register being returned |

## Verification
The assertions assume that pushes arrive in program order with non-decreasing sequence numbers. They also assume that live sequence numbers span less than half the number space, and that the rename logic treats `full` and `busy` as stalls. The directed stimulus only pushes increasing sequence numbers, including a run that crosses the wrap point. Dropped pushes and ignored commits are offered on purpose while full or busy to exercise R2 and R9. Their effect is judged only through later retire behaviour at the ports.

// File: rtl/undo_log_pkg.sv
package undo_log_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

endpackage

// File: rtl/undo_log_ram.sv
module undo_log_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 36,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_old_idx,
    input  logic [PTR_W-1:0] rd_young_idx,
    output logic [WIDTH-1:0] rd_old_data,
    output logic [WIDTH-1:0] rd_young_data
);

    logic [WIDTH-1:0] slot_d [DEPTH];
    logic [WIDTH-1:0] slot_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            slot_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_q[i] <= slot_d[i];
        end
    end

    assign rd_old_data   = slot_q[rd_old_idx];
    assign rd_young_data = slot_q[rd_young_idx];

endmodule

// File: rtl/undo_log_ptrs.sv
module undo_log_ptrs #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop_old,
    input  logic             pop_young,
    output logic [PTR_W-1:0] old_idx,
    output logic [PTR_W-1:0] young_idx,
    output logic [PTR_W-1:0] wr_idx,
    output logic [CNT_W-1:0] occ,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST_IDX  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } ptr_s;

    ptr_s ptr_d, ptr_q;

    function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] step_down(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_IDX : p - PTR_W'(1);
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (push) begin
            ptr_d.tail = step_up(ptr_q.tail);
        end else if (pop_young) begin
            ptr_d.tail = step_down(ptr_q.tail);
        end
        if (pop_old) begin
            ptr_d.head = step_up(ptr_q.head);
        end
        ptr_d.cnt = ptr_q.cnt + CNT_W'(push) - CNT_W'(pop_old) - CNT_W'(pop_young);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign old_idx   = ptr_q.head;
    assign wr_idx    = ptr_q.tail;
    assign young_idx = step_down(ptr_q.tail);
    assign occ       = ptr_q.cnt;
    assign full      = (ptr_q.cnt == DEPTH_CNT);
    assign empty     = (ptr_q.cnt == '0);

endmodule

// File: rtl/undo_log_ctrl.sv
module undo_log_ctrl
    import undo_log_pkg::*;
#(
    parameter int SEQ_W  = 16,
    parameter int AREG_W = 5,
    parameter int PREG_W = 7,
    localparam int ENT_W = 1 + SEQ_W + AREG_W + 2 * PREG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic              full,
    input  logic              empty,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic [ENT_W-1:0]  old_ent,
    input  logic [ENT_W-1:0]  young_ent,
    output logic              push_en,
    output logic              pop_old,
    output logic              pop_young,
    output logic              busy,
    output logic              restore_valid,
    output logic [AREG_W-1:0] restore_areg,
    output logic [PREG_W-1:0] restore_preg,
    output logic              free_valid,
    output logic [PREG_W-1:0] free_preg
);

    typedef struct packed {
        logic              marker;
        logic [SEQ_W-1:0]  seq;
        logic [AREG_W-1:0] areg;
        logic [PREG_W-1:0] new_preg;
        logic [PREG_W-1:0] prev_preg;
    } entry_t;

    typedef struct packed {
        walk_state_e       state;
        logic [SEQ_W-1:0]  bound;
        logic              rst_v;
        logic [AREG_W-1:0] rst_areg;
        logic [PREG_W-1:0] rst_preg;
        logic              fre_v;
        logic [PREG_W-1:0] fre_preg;
    } ctrl_s;

    ctrl_s  ctl_d, ctl_q;
    entry_t oldest, youngest;

    // Wrap-safe ordering: a is younger than b when a - b is positive (R10)
    function automatic logic is_younger(input logic [SEQ_W-1:0] a,
                                        input logic [SEQ_W-1:0] b);
        logic signed [SEQ_W-1:0] diff;
        diff = signed'(a - b);
        return diff > 0;
    endfunction

    always_comb begin
        oldest   = entry_t'(old_ent);
        youngest = entry_t'(young_ent);
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rst_v    = 1'b0;
        ctl_d.fre_v    = 1'b0;
        pop_old        = 1'b0;
        pop_young      = 1'b0;
        push_en        = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                push_en = push_valid && !full;
                if (squash_valid) begin
                    ctl_d.state = ST_WALK;
                    ctl_d.bound = squash_seq;
                end else if (commit_valid && !empty && oldest.seq == commit_seq) begin
                    pop_old = 1'b1;
                    if (!oldest.marker) begin
                        ctl_d.fre_v    = 1'b1;
                        ctl_d.fre_preg = oldest.prev_preg;
                    end
                end
            end
            ST_WALK: begin
                if (!empty && is_younger(youngest.seq, ctl_q.bound)) begin
                    pop_young = 1'b1;
                    if (!youngest.marker) begin
                        ctl_d.rst_v    = 1'b1;
                        ctl_d.rst_areg = youngest.areg;
                        ctl_d.rst_preg = youngest.prev_preg;
                        ctl_d.fre_v    = 1'b1;
                        ctl_d.fre_preg = youngest.new_preg;
                    end
                end else begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy          = (ctl_q.state == ST_WALK);
    assign restore_valid = ctl_q.rst_v;
    assign restore_areg  = ctl_q.rst_areg;
    assign restore_preg  = ctl_q.rst_preg;
    assign free_valid    = ctl_q.fre_v;
    assign free_preg     = ctl_q.fre_preg;

endmodule

// File: rtl/rename_undo_log.sv
module rename_undo_log #(
    parameter int DEPTH  = 16,
    parameter int SEQ_W  = 16,
    parameter int AREG_W = 5,
    parameter int PREG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic              push_has_dest,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_new_preg,
    input  logic [PREG_W-1:0] push_prev_preg,
    output logic              full,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              busy,
    output logic              restore_valid,
    output logic [AREG_W-1:0] restore_areg,
    output logic [PREG_W-1:0] restore_preg,
    output logic              free_valid,
    output logic [PREG_W-1:0] free_preg
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam int ENT_W = 1 + SEQ_W + AREG_W + 2 * PREG_W;

    logic [PTR_W-1:0] old_idx, young_idx, wr_idx;
    logic [CNT_W-1:0] occ_w;
    logic             empty_w;
    logic             push_en, pop_old, pop_young;
    logic [ENT_W-1:0] wr_ent, old_ent, young_ent;

    // Marker entries keep only the sequence number; register fields are zero
    assign wr_ent = push_has_dest
        ? {1'b0, push_seq, push_areg, push_new_preg, push_prev_preg}
        : {1'b1, push_seq, {(AREG_W + 2 * PREG_W){1'b0}}};

    undo_log_ptrs #(
        .DEPTH (DEPTH)
    ) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_en),
        .pop_old   (pop_old),
        .pop_young (pop_young),
        .old_idx   (old_idx),
        .young_idx (young_idx),
        .wr_idx    (wr_idx),
        .occ       (occ_w),
        .full      (full),
        .empty     (empty_w)
    );

    undo_log_ram #(
        .DEPTH (DEPTH),
        .WIDTH (ENT_W)
    ) u_ram (
        .clk           (clk),
        .wr_en         (push_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_ent),
        .rd_old_idx    (old_idx),
        .rd_young_idx  (young_idx),
        .rd_old_data   (old_ent),
        .rd_young_data (young_ent)
    );

    undo_log_ctrl #(
        .SEQ_W  (SEQ_W),
        .AREG_W (AREG_W),
        .PREG_W (PREG_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_valid    (push_valid),
        .full          (full),
        .empty         (empty_w),
        .commit_valid  (commit_valid),
        .commit_seq    (commit_seq),
        .squash_valid  (squash_valid),
        .squash_seq    (squash_seq),
        .old_ent       (old_ent),
        .young_ent     (young_ent),
        .push_en       (push_en),
        .pop_old       (pop_old),
        .pop_young     (pop_young),
        .busy          (busy),
        .restore_valid (restore_valid),
        .restore_areg  (restore_areg),
        .restore_preg  (restore_preg),
        .free_valid    (free_valid),
        .free_preg     (free_preg)
    );

endmodule

// File: rtl/undo_log_chk.sv
module undo_log_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             full,
    input logic             busy,
    input logic             squash_valid,
    input logic             restore_valid,
    input logic             free_valid,
    input logic [CNT_W-1:0] occ
);

    p_restore_with_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> free_valid);

    p_busy_from_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(squash_valid));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (occ <= $past(occ)));

    p_bounded_occ_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    p_walk_no_growth_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (occ <= $past(occ)));

    p_retire_free_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (free_valid && !restore_valid) |-> !busy);

    p_retire_pops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (free_valid && !restore_valid) |-> (occ <= $past(occ)));

    p_restore_pops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> (occ < $past(occ)));

endmodule

bind rename_undo_log undo_log_chk #(
    .DEPTH (DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .full          (full),
    .busy          (busy),
    .squash_valid  (squash_valid),
    .restore_valid (restore_valid),
    .free_valid    (free_valid),
    .occ           (occ_w)
);

// File: tb/rename_undo_log_tb.sv
`timescale 1ns/1ps
module rename_undo_log_tb;

    localparam int DEPTH  = 16;
    localparam int SEQ_W  = 16;
    localparam int AREG_W = 5;
    localparam int PREG_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_valid = 1'b0;
    logic [SEQ_W-1:0]  push_seq = '0;
    logic              push_has_dest = 1'b0;
    logic [AREG_W-1:0] push_areg = '0;
    logic [PREG_W-1:0] push_new_preg = '0;
    logic [PREG_W-1:0] push_prev_preg = '0;
    logic              full;
    logic              commit_valid = 1'b0;
    logic [SEQ_W-1:0]  commit_seq = '0;
    logic              squash_valid = 1'b0;
    logic [SEQ_W-1:0]  squash_seq = '0;
    logic              busy;
    logic              restore_valid;
    logic [AREG_W-1:0] restore_areg;
    logic [PREG_W-1:0] restore_preg;
    logic              free_valid;
    logic [PREG_W-1:0] free_preg;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rename_undo_log #(
        .DEPTH (DEPTH), .SEQ_W (SEQ_W), .AREG_W (AREG_W), .PREG_W (PREG_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .push_valid (push_valid), .push_seq (push_seq), .push_has_dest (push_has_dest),
        .push_areg (push_areg), .push_new_preg (push_new_preg), .push_prev_preg (push_prev_preg),
        .full (full),
        .commit_valid (commit_valid), .commit_seq (commit_seq),
        .squash_valid (squash_valid), .squash_seq (squash_seq),
        .busy (busy),
        .restore_valid (restore_valid), .restore_areg (restore_areg), .restore_preg (restore_preg),
        .free_valid (free_valid), .free_preg (free_preg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic push_one(input logic [SEQ_W-1:0] s, input logic has,
                            input logic [AREG_W-1:0] a, input logic [PREG_W-1:0] np,
                            input logic [PREG_W-1:0] pp);
        push_valid = 1'b1; push_seq = s; push_has_dest = has;
        push_areg = a; push_new_preg = np; push_prev_preg = pp;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic commit_chk(input string req, input logic [SEQ_W-1:0] s,
                              input logic exp_free, input logic [PREG_W-1:0] exp_preg);
        commit_valid = 1'b1; commit_seq = s;
        @(negedge clk);
        commit_valid = 1'b0;
        chk(req, 32'(free_valid), 32'(exp_free));
        if (exp_free) chk(req, 32'(free_preg), 32'(exp_preg));
    endtask

    task automatic pulse_chk(input string req, input logic exp_rst, input logic [AREG_W-1:0] ea,
                             input logic [PREG_W-1:0] ep, input logic [PREG_W-1:0] ef,
                             input logic exp_busy);
        chk(req, 32'(busy), 32'(exp_busy));
        chk(req, 32'(restore_valid), 32'(exp_rst));
        chk(req, 32'(free_valid), 32'(exp_rst));
        if (exp_rst) begin
            chk(req, 32'(restore_areg), 32'(ea));
            chk(req, 32'(restore_preg), 32'(ep));
            chk(req, 32'(free_preg), 32'(ef));
        end
    endtask

    task automatic t_reset();
        chk("R1 full", 32'(full), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 restore", 32'(restore_valid), 0);
        chk("R1 free", 32'(free_valid), 0);
    endtask

    task automatic t_retire();
        push_one(16'd1, 1'b1, 5'd3, 7'd40, 7'd3);
        push_one(16'd2, 1'b0, 5'd0, 7'd0, 7'd0);
        commit_chk("R3 retire dest", 16'd1, 1'b1, 7'd3);
        commit_chk("R4 retire marker", 16'd2, 1'b0, 7'd0);
        commit_chk("R5 commit on empty", 16'd5, 1'b0, 7'd0);
        push_one(16'd10, 1'b1, 5'd7, 7'd41, 7'd5);
        commit_chk("R5 older commit ignored", 16'd9, 1'b0, 7'd0);
        commit_chk("R5 entry kept", 16'd10, 1'b1, 7'd5);
    endtask

    task automatic t_rollback();
        push_one(16'd20, 1'b1, 5'd1, 7'd50, 7'd1);
        push_one(16'd21, 1'b0, 5'd0, 7'd0, 7'd0);
        push_one(16'd22, 1'b1, 5'd2, 7'd51, 7'd2);
        push_one(16'd23, 1'b1, 5'd3, 7'd52, 7'd3);
        squash_valid = 1'b1; squash_seq = 16'd20;
        @(negedge clk);
        squash_valid = 1'b0;
        pulse_chk("R6 busy rises", 1'b0, '0, '0, '0, 1'b1);
        commit_valid = 1'b1; commit_seq = 16'd20;   // ignored while busy (R9)
        push_valid = 1'b1; push_seq = 16'd30; push_has_dest = 1'b1;
        push_areg = 5'd9; push_new_preg = 7'd99; push_prev_preg = 7'd9;
        @(negedge clk);
        commit_valid = 1'b0; push_valid = 1'b0;
        pulse_chk("R6 undo youngest", 1'b1, 5'd3, 7'd3, 7'd52, 1'b1);
        @(negedge clk);
        pulse_chk("R6 undo next", 1'b1, 5'd2, 7'd2, 7'd51, 1'b1);
        @(negedge clk);
        pulse_chk("R7 marker silent", 1'b0, '0, '0, '0, 1'b1);
        @(negedge clk);
        pulse_chk("R8 walk ends", 1'b0, '0, '0, '0, 1'b0);
        commit_chk("R8 R9 boundary entry kept", 16'd20, 1'b1, 7'd1);
        commit_chk("R9 push during walk dropped", 16'd30, 1'b0, 7'd0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) begin
            if (i == DEPTH - 1) chk("R2 not full yet", 32'(full), 0);
            push_one(16'(100 + i), 1'b1, 5'(i), 7'(64 + i), 7'(i));
        end
        chk("R2 full", 32'(full), 1);
        push_one(16'd200, 1'b1, 5'd1, 7'd1, 7'd77);
        for (int i = 0; i < DEPTH; i++) begin
            commit_chk("R2 R3 retire in order", 16'(100 + i), 1'b1, 7'(i));
            if (i == 0) chk("R2 full clears", 32'(full), 0);
        end
        commit_chk("R2 push while full dropped", 16'd200, 1'b0, 7'd0);
    endtask

    task automatic t_wrap();
        push_one(16'hFFFE, 1'b1, 5'd4, 7'd60, 7'd4);
        push_one(16'hFFFF, 1'b0, 5'd0, 7'd0, 7'd0);
        push_one(16'h0001, 1'b1, 5'd5, 7'd61, 7'd5);
        squash_valid = 1'b1; squash_seq = 16'hFFFE;
        @(negedge clk);
        squash_valid = 1'b0;
        pulse_chk("R10 busy", 1'b0, '0, '0, '0, 1'b1);
        @(negedge clk);
        pulse_chk("R10 wrapped entry younger", 1'b1, 5'd5, 7'd5, 7'd61, 1'b1);
        @(negedge clk);
        pulse_chk("R10 R7 marker", 1'b0, '0, '0, '0, 1'b1);
        @(negedge clk);
        pulse_chk("R10 stop at boundary", 1'b0, '0, '0, '0, 1'b0);
        commit_chk("R10 boundary kept", 16'hFFFE, 1'b1, 7'd4);
    endtask

    task automatic t_squash_beats_commit();
        push_one(16'd40, 1'b1, 5'd6, 7'd70, 7'd6);
        squash_valid = 1'b1; squash_seq = 16'd40;
        commit_valid = 1'b1; commit_seq = 16'd40;
        @(negedge clk);
        squash_valid = 1'b0; commit_valid = 1'b0;
        chk("R9 commit dropped on squash", 32'(free_valid), 0);
        chk("R9 busy", 32'(busy), 1);
        @(negedge clk);
        pulse_chk("R8 nothing younger", 1'b0, '0, '0, '0, 1'b0);
        commit_chk("R9 entry survives", 16'd40, 1'b1, 7'd6);
        squash_valid = 1'b1; squash_seq = 16'd50;
        @(negedge clk);
        squash_valid = 1'b0;
        chk("R8 empty walk busy", 32'(busy), 1);
        @(negedge clk);
        chk("R8 empty walk ends", 32'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_retire();
        t_rollback();
        t_full();
        t_wrap();
        t_squash_beats_commit();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule